// File: doc/BRIEF.md
# Arithmetic Flag and Status Register Unit

This block sits beside the accumulator of a small RISC core. It combines an operand-level arithmetic/logic stage with the core's status byte. The stage takes two operands and an operation selector and returns the result combinationally. When an operation is marked valid, the block updates the carry, nibble carry and zero flags on the next clock edge.

The same status byte also holds a data-memory bank select bit and two active-low reset-cause bits. Software reads the byte as one memory-mapped location and may write it, but only the bank bit and the arithmetic flags accept writes. A sleep-entry pulse and a watchdog-expiry pulse come in from elsewhere in the chip and set the reset-cause bits. After a restart, firmware reads those bits to tell which event stopped the core. The bank bit is also driven out directly to the data-memory address logic.

Top module: `arith_flag_unit`

## Requirements
- R1: Operation code 0 (add) gives result = (a + b) mod 256, and C becomes the ninth sum bit.
- R2: For add, DC becomes the carry out of the low four bits: 0x38 + 0x38 gives 0x70 with DC = 1.
- R3: Operation code 1 (subtract) gives result = (a - b) mod 256. C = 1 when a >= b (no borrow), and DC = 1 when a[3:0] >= b[3:0].
- R4: For codes 0 to 5, Z becomes 1 exactly when the result is zero.
- R5: Codes 2 (AND), 3 (OR), 4 (XOR) and 5 (pass a) update only Z and leave C and DC unchanged.
- R6: Codes 6 and 7 are reserved: the result is 0 and no flag changes.
- R7: The read byte is bit0 C, bit1 DC, bit2 Z, bit3 nPD, bit4 nTO, bit5 RP0, and bits 7:6 always read 0.
- R8: A software write loads C, DC, Z and RP0 from write bits 0, 1, 2 and 5. Bits 3 and 4 of the write data have no effect.
- R9: When a valid operation and a write fall in the same cycle, the flags the operation updates take the operation's values. Every other writable bit takes the written value.
- R10: Reset sets nPD = 1, nTO = 1 and RP0 = 0. C, DC and Z are unspecified after reset.
- R11: A sleep pulse sets nPD = 0 and nTO = 1. A timeout pulse sets nTO = 0. When both pulses arrive together, both bits become 0.
- R12: The bank_sel output always equals RP0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| op_valid | input | 1 | Apply this cycle's operation to the flags |
| op_code | input | 3 | Operation selector |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Combinational operation result |
| reg_wr | input | 1 | Software write strobe for the status byte |
| reg_wdata | input | 8 | Software write data |
| reg_rdata | output | 8 | Status byte read value |
| sleep_evt | input | 1 | Sleep-entry pulse |
| timeout_evt | input | 1 | Watchdog-expiry pulse |
| bank_sel | output | 1 | Data-memory bank select |

## Verification
The bench builds the block with the default operand width of 8. At that width, random operands exercise the four-bit nibble boundary and the full carry-out range of the byte. A subtraction model that compares operands is checked against the hardware's complement-and-add path. Directed cases cover the 0x38 + 0x38 nibble carry, equal and unequal borrows, and reserved codes. They also cover same-cycle write/operation collisions, simultaneous sleep and timeout pulses, and a reset in the middle of a run.

// File: rtl/afu_pkg.sv
package afu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_PASS = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } afu_op_e;

    // Bit positions inside the software-visible status byte
    localparam int POS_C   = 0;
    localparam int POS_DC  = 1;
    localparam int POS_Z   = 2;
    localparam int POS_NPD = 3;
    localparam int POS_NTO = 4;
    localparam int POS_RP0 = 5;
    localparam int STAT_BITS = 6;

    typedef struct packed {
        logic rp0;
        logic n_to;
        logic n_pd;
        logic z;
        logic dc;
        logic c;
    } afu_stat_t;

    typedef struct packed {
        logic upd_cdc;
        logic upd_z;
        logic c;
        logic dc;
        logic z;
    } afu_flags_t;

endpackage

// File: rtl/afu_alu.sv
module afu_alu
    import afu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  afu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res,
    output afu_flags_t          flags
);
    localparam int NIB_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [DATA_W:0]   sum_w;
    logic [NIB_W:0]    sum_n;

    always_comb begin
        cin   = (op == OP_SUB);
        b_eff = (op == OP_SUB) ? ~b : b;
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        sum_n = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};

        res           = '0;
        flags.upd_cdc = 1'b0;
        flags.upd_z   = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res           = sum_w[DATA_W-1:0];
                flags.upd_cdc = 1'b1;
                flags.upd_z   = 1'b1;
            end
            OP_AND: begin
                res         = a & b;
                flags.upd_z = 1'b1;
            end
            OP_OR: begin
                res         = a | b;
                flags.upd_z = 1'b1;
            end
            OP_XOR: begin
                res         = a ^ b;
                flags.upd_z = 1'b1;
            end
            OP_PASS: begin
                res         = a;
                flags.upd_z = 1'b1;
            end
            default: begin
                res = '0;
            end
        endcase
        flags.c  = sum_w[DATA_W];
        flags.dc = sum_n[NIB_W];
        flags.z  = (res == '0);
    end
endmodule

// File: rtl/afu_next.sv
module afu_next
    import afu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  afu_stat_t          cur,
    input  afu_flags_t         flags,
    input  logic               op_valid,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               sleep_evt,
    input  logic               timeout_evt,
    output afu_stat_t          nxt
);
    always_comb begin
        nxt = cur;
        // Software write: reset-cause bits are not writable
        if (wr) begin
            nxt.c   = wdata[POS_C];
            nxt.dc  = wdata[POS_DC];
            nxt.z   = wdata[POS_Z];
            nxt.rp0 = wdata[POS_RP0];
        end
        // Operation results override the write for the flags they touch
        if (op_valid) begin
            if (flags.upd_cdc) begin
                nxt.c  = flags.c;
                nxt.dc = flags.dc;
            end
            if (flags.upd_z) begin
                nxt.z = flags.z;
            end
        end
        if (sleep_evt) begin
            nxt.n_pd = 1'b0;
            nxt.n_to = 1'b1;
        end
        if (timeout_evt) begin
            nxt.n_to = 1'b0;
        end
    end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import afu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sleep_evt,
    input  logic              timeout_evt,
    output logic              bank_sel
);
    localparam int PAD_W = DATA_W - STAT_BITS;

    afu_op_e    op_e;
    afu_flags_t alu_flags;
    afu_stat_t  stat_d, stat_q;

    assign op_e = afu_op_e'(op_code);

    afu_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (op_e),
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (result),
        .flags (alu_flags)
    );

    afu_next #(.DATA_W(DATA_W)) u_next (
        .cur         (stat_q),
        .flags       (alu_flags),
        .op_valid    (op_valid),
        .wr          (reg_wr),
        .wdata       (reg_wdata),
        .sleep_evt   (sleep_evt),
        .timeout_evt (timeout_evt),
        .nxt         (stat_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '{rp0: 1'b0, n_to: 1'b1, n_pd: 1'b1, z: 1'b0, dc: 1'b0, c: 1'b0};
        end else begin
            stat_q <= stat_d;
        end
    end

    assign reg_rdata = {{PAD_W{1'b0}}, stat_q};
    assign bank_sel  = stat_q.rp0;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:STAT_BITS] == '0); // R7

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd5) |=> (reg_rdata[POS_Z] == ($past(result) == '0))); // R4

    AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 3'd2 && op_code <= 3'd5 && !reg_wr)
        |=> ($stable(reg_rdata[POS_C]) && $stable(reg_rdata[POS_DC]))); // R5

    AST_CAUSE_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !sleep_evt && !timeout_evt)
        |=> ($stable(reg_rdata[POS_NTO]) && $stable(reg_rdata[POS_NPD]))); // R8

    AST_SLEEP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_evt && !timeout_evt) |=> (!reg_rdata[POS_NPD] && reg_rdata[POS_NTO])); // R11

    AST_BANK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel == reg_rdata[POS_RP0]); // R12

    AST_RSV_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 3'd6 && !reg_wr) |=> $stable(reg_rdata[2:0])); // R6
endmodule

// File: tb/arith_flag_unit_test.sv
module arith_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic [7:0] result;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_evt = 1'b0, timeout_evt = 1'b0;
    logic       bank_sel;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic m_c, m_dc, m_z, m_npd, m_nto, m_rp0;
    logic k_c, k_dc, k_z;

    always #5 clk = ~clk;

    arith_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sleep_evt(sleep_evt), .timeout_evt(timeout_evt), .bank_sel(bank_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_res(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            3'd0: return 8'((int'(a) + int'(b)) & 255);
            3'd1: return 8'((int'(a) - int'(b) + 256) & 255);
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return a ^ b;
            3'd5: return a;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_stat();
        check("R7 reserved bits", int'(reg_rdata[7:6]), 0);
        check("R11 nPD", int'(reg_rdata[3]), int'(m_npd));
        check("R8 nTO", int'(reg_rdata[4]), int'(m_nto));
        check("R12 RP0", int'(reg_rdata[5]), int'(m_rp0));
        check("R12 bank_sel", int'(bank_sel), int'(m_rp0));
        if (k_c)  check("R1 C", int'(reg_rdata[0]), int'(m_c));
        if (k_dc) check("R2 DC", int'(reg_rdata[1]), int'(m_dc));
        if (k_z)  check("R4 Z", int'(reg_rdata[2]), int'(m_z));
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic wr, input logic [7:0] wd,
                        input logic sl, input logic to);
        logic [7:0] r;
        @(negedge clk);
        op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
        reg_wr = wr; reg_wdata = wd; sleep_evt = sl; timeout_evt = to;
        #1;
        r = exp_res(op, a, b);
        if (op >= 3'd6) check("R6 reserved result", int'(result), int'(r));
        else            check("R1 R3 result", int'(result), int'(r));
        if (wr) begin
            m_c = wd[0]; m_dc = wd[1]; m_z = wd[2]; m_rp0 = wd[5];
            k_c = 1'b1; k_dc = 1'b1; k_z = 1'b1;
        end
        if (v && op <= 3'd1) begin
            if (op == 3'd0) begin
                m_c  = (int'(a) + int'(b)) > 255;
                m_dc = (int'(a[3:0]) + int'(b[3:0])) > 15;
            end else begin
                m_c  = a >= b;
                m_dc = a[3:0] >= b[3:0];
            end
            k_c = 1'b1; k_dc = 1'b1;
        end
        if (v && op <= 3'd5) begin
            m_z = (r == 8'h00);
            k_z = 1'b1;
        end
        if (sl) begin m_npd = 1'b0; m_nto = 1'b1; end
        if (to) m_nto = 1'b0;
        @(posedge clk);
        #2;
        check_stat();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0; reg_wr = 1'b0; sleep_evt = 1'b0; timeout_evt = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_npd = 1'b1; m_nto = 1'b1; m_rp0 = 1'b0;
        k_c = 1'b0; k_dc = 1'b0; k_z = 1'b0;
        #1;
        // R10 reset values
        check("R10 nPD after reset", int'(reg_rdata[3]), 1);
        check("R10 nTO after reset", int'(reg_rdata[4]), 1);
        check("R10 RP0 after reset", int'(reg_rdata[5]), 0);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R2 nibble carry 0x38 + 0x38
        step(1, 3'd0, 8'h38, 8'h38, 0, 8'h00, 0, 0);
        check("R2 DC on 0x38+0x38", int'(reg_rdata[1]), 1);
        check("R1 C clear on 0x38+0x38", int'(reg_rdata[0]), 0);
        // R1 full carry, zero result
        step(1, 3'd0, 8'hFF, 8'h01, 0, 8'h00, 0, 0);
        check("R1 C on 0xFF+0x01", int'(reg_rdata[0]), 1);
        check("R4 Z on zero sum", int'(reg_rdata[2]), 1);
        // R3 subtract with borrow
        step(1, 3'd1, 8'h05, 8'h07, 0, 8'h00, 0, 0);
        check("R3 borrow C", int'(reg_rdata[0]), 0);
        check("R3 borrow DC", int'(reg_rdata[1]), 0);
        // R3 equal operands
        step(1, 3'd1, 8'h5A, 8'h5A, 0, 8'h00, 0, 0);
        check("R3 equal C", int'(reg_rdata[0]), 1);
        check("R3 equal Z", int'(reg_rdata[2]), 1);
        // R5 logic keeps C/DC
        step(1, 3'd2, 8'hF0, 8'h0F, 0, 8'h00, 0, 0);
        check("R5 C kept", int'(reg_rdata[0]), 1);
        // R6 reserved op keeps flags
        step(1, 3'd7, 8'h00, 8'h00, 0, 8'h00, 0, 0);
        check("R6 Z kept", int'(reg_rdata[2]), 1);
        // R8 write trying to clear reset-cause bits
        step(0, 3'd0, 8'h00, 8'h00, 1, 8'h00, 0, 0);
        check("R8 nTO unchanged", int'(reg_rdata[4]), 1);
        // R9 collision: logic op with write setting C, Z, RP0
        step(1, 3'd3, 8'h01, 8'h00, 1, 8'h27, 0, 0);
        check("R9 Z from op", int'(reg_rdata[2]), 0);
        check("R9 C from write", int'(reg_rdata[0]), 1);
        check("R9 RP0 from write", int'(reg_rdata[5]), 1);
        // R11 sleep then timeout then both
        step(0, 3'd0, 8'h00, 8'h00, 0, 8'h00, 1, 0);
        step(0, 3'd0, 8'h00, 8'h00, 0, 8'h00, 0, 1);
        step(0, 3'd0, 8'h00, 8'h00, 0, 8'h00, 1, 1);
        check("R11 both events nPD", int'(reg_rdata[3]), 0);
        check("R11 both events nTO", int'(reg_rdata[4]), 0);
        do_reset();

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 3'($urandom), 8'($urandom), 8'($urandom),
                 ($urandom % 5) == 0, 8'($urandom),
                 ($urandom % 40) == 0, ($urandom % 40) == 0);
            if ((i % 700) == 699) do_reset();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule